// File: doc/BRIEF.md
# GPIO Register Bank with Polarity Inversion

This block is the register file behind a small general-purpose I/O expander. A bus-interface block hands it byte writes and read requests over a simple strobe interface. Each request carries a 2-bit register code. The bank holds three writable registers: the output latch, the per-bit polarity mask and the per-bit direction mask. A fourth, read-only view returns the sampled pin levels.

Each pin is driven only when its direction bit selects output. The pin levels pass through a two-flop synchronizer. On a read of the input view, each bit is XORed with its polarity bit. A read of the output latch returns the stored flip-flop value, whatever level the pin actually shows. Reset is synchronous and active high, and it returns every register to its default.

Top module: `gpio_regbank`

## Requirements
- R1: While reset is high and after it is released, the direction register is all ones, so pin_oe is 0 for every pin. The output register is all ones (pin_out = 0xFF) and the polarity register is 0x00.
- R2: A direction bit of 0 makes its pin an output (pin_oe bit 1, driving the output-register bit). A direction bit of 1 makes it an input (pin_oe bit 0), and its output-register bit then drives nothing.
- R3: A write updates the addressed register on the clock edge that samples wr_en. A new output or direction value therefore appears on pin_out/pin_oe in the cycle after the write strobe.
- R4: A read of code 1 (output register) returns the stored value, not the pin level, even when the pin is an input or an external level differs.
- R5: A read of code 0 returns the synchronized pin level for every bit, whether that pin is configured as input or output.
- R6: In a code 0 read, a bit whose polarity bit is 1 is returned inverted, and a bit whose polarity bit is 0 is returned unchanged.
- R7: A write with code 0 has no effect. The output, polarity and direction registers and both pin buses keep their values.
- R8: The register codes are 0 = input view, 1 = output, 2 = polarity, 3 = direction. rd_data and a one-cycle rd_valid pulse appear in the cycle after rd_en is sampled. rd_valid is 0 when no read was requested.
- R9: A pin change made before clock edge E1 is not yet visible to a read sampled at edge E2. It is visible to a read sampled at edge E3.
- R10: Asserting reset in the middle of operation returns all registers to their R1 defaults and holds them there while reset stays high, even if writes are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at reg_sel |
| rd_en | input | 1 | Read request for the register at reg_sel |
| reg_sel | input | 2 | Register code (0 input view, 1 output, 2 polarity, 3 direction) |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| rd_valid | output | 1 | High for one cycle when rd_data holds a read result |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output latch value toward the pads |
| pin_oe | output | WIDTH | Per-pin driver enable (1 = drive) |

## Verification
Most internal faults show up within one cycle. A wrong direction or output flop is visible on pin_oe or pin_out in the cycle after the write that should have set it. A wrong polarity bit or a mis-decoded register code shows up in the first read result that follows, one cycle after rd_en. Faults in the synchronizer only show through code 0 reads. The bench therefore reads immediately before and after the two-stage window, so that a stage too many or too few changes a result. Each register is read back after every write that should not have touched it.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_DIR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_regbank_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] OUT_RST = '1,
  parameter logic [WIDTH-1:0] POL_RST = '0,
  parameter logic [WIDTH-1:0] DIR_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] dir_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= OUT_RST;
      pol_q <= POL_RST;
      dir_q <= DIR_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_OUT: out_q <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> dir_q == $past(wr_data));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == 2'd1) |=> $stable(out_q));

  // R7
  pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == 2'd2) |=> $stable(pol_q));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_regbank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  input  logic [WIDTH-1:0] in_sync,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] pol_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  logic [WIDTH-1:0] in_view;
  logic [WIDTH-1:0] mux_val;

  for (genvar b = 0; b < WIDTH; b++) begin : g_pol
    assign in_view[b] = in_sync[b] ^ pol_q[b];
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_IN:  mux_val = in_view;
      SEL_OUT: mux_val = out_q;
      SEL_POL: mux_val = pol_q;
      default: mux_val = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux_val;
    end
  end

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R4
  rd_out_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd1) |=> rd_data == $past(out_q));

  // R6
  rd_in_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd0) |=> rd_data == $past(in_sync ^ pol_q));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] pol_q;
  logic [WIDTH-1:0] dir_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(in_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(reg_sel),
    .wr_data(wr_data), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q)
  );

  gpio_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(reg_sel),
    .in_sync(in_sync), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  // R1
  rst_inputs_chk: assert property (@(posedge clk)
    rst |=> pin_oe == '0);

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd3) |=> pin_oe == ~$past(wr_data));
endmodule

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   reg_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  gpio_regbank #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, logic [W-1:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read results as they arrive
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R8: unexpected rd_valid, actual %02h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 defaults held during reset
    check("R1 oe in reset", pin_oe, 8'h00);
    check("R1 out in reset", pin_out, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    check("R8 rd_valid idle", {7'd0, rd_valid}, 8'h00);
    rd(2'd1, 8'hFF, "R1 out default");
    rd(2'd2, 8'h00, "R1 pol default");
    rd(2'd3, 8'hFF, "R1 dir default");

    // R2 R3 direction and output writes
    wr(2'd3, 8'hF0);
    check("R3 oe after dir write", pin_oe, 8'h0F);
    check("R2 out latch unchanged", pin_out, 8'hFF);
    wr(2'd1, 8'h5A);
    check("R3 pin_out after write", pin_out, 8'h5A);
    check("R2 inputs not driven", pin_oe & 8'hF0, 8'h00);

    // R5 input view regardless of direction
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd0, 8'h3C, "R5 input view");
    rd(2'd1, 8'h5A, "R4 out reads latch not pin");

    // R6 polarity
    wr(2'd2, 8'hFF);
    rd(2'd0, 8'hC3, "R6 full inversion");
    wr(2'd2, 8'h81);
    rd(2'd0, 8'hBD, "R6 partial inversion");

    // R7 write to input code ignored
    wr(2'd0, 8'h00);
    check("R7 pin_out kept", pin_out, 8'h5A);
    check("R7 pin_oe kept", pin_oe, 8'h0F);
    rd(2'd0, 8'hBD, "R7 input view kept");
    rd(2'd1, 8'h5A, "R7 out kept");
    rd(2'd2, 8'h81, "R7 pol kept");
    rd(2'd3, 8'hF0, "R7 dir kept");

    // R9 synchronizer window
    @(negedge clk);
    pin_in = 8'h00;
    @(negedge clk);
    rd_en = 1'b1; reg_sel = 2'd0;
    exp_q.push_back(8'hBD); tag_q.push_back("R9 not yet visible at E2");
    @(negedge clk);
    exp_q.push_back(8'h81); tag_q.push_back("R9 visible at E3");
    @(negedge clk);
    rd_en = 1'b0;

    // R10 mid-operation reset, writes ignored while held
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd1; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 oe held in reset", pin_oe, 8'h00);
    check("R10 out held in reset", pin_out, 8'hFF);
    rst = 1'b0;
    rd(2'd2, 8'h00, "R10 pol default");
    rd(2'd3, 8'hFF, "R10 dir default");

    repeat (4) @(negedge clk);
    check("R8 all reads returned", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule